// File: doc/BRIEF.md
# Bridge Global Control and Status Register Unit

This block is the global control and status register logic of a host-to-expansion-bus bridge. Software reaches it through a two-word read/write port. One word is the control register. It holds four interrupt enables, a programmable clock-ratio selector and the software reset bit for the external bus. The other word is the status register, which holds four sticky error flags that software clears by writing one.

Hardware event inputs set the flags. Three of them are a parity error, a system error and an internal error response. The fourth flag comes from a built-in retry timer. That timer watches a delayed-read buffer and declares a discard when the external master does not return within 2^15 clock cycles.

The block merges the enabled flags into a single CPU interrupt. It drives the external bus reset level directly from the reset bit and emits a one-cycle internal reset strobe when that bit is set from a cleared state. It also presents the effective clock-divide code: the programmed code when it is non-zero, otherwise the auto-detected code.

Top module: `brg_csr_unit`

## Requirements
- R1: After synchronous reset the control word reads 0x0000_0001, the status word reads 0, `ext_rst_out` is 1, and `cpu_irq` and `int_rst_strobe` are 0.
- R2: A write to address 0 stores bits 18:16 (divide code), 15, 13, 12, 11 (enables) and 0 (reset bit). All other bits, including 14 and 10:1, read back as zero.
- R3: `div_code` equals the programmed code in bits 18:16 when that code is non-zero. When it is 000, `div_code` equals `auto_div`. The codes mean: 001-101 divide by 1-5, 110 divide by 1.5, 111 reserved.
- R4: `div_reserved` is 1 exactly when the effective `div_code` is 111, and 111 is still passed to `div_code`.
- R5: A parity, system or internal error input sampled high at a clock edge sets its status flag at that edge. The flags sit at status bits 13, 12 and 11. The flag stays set after the input falls.
- R6: A write to address 1 clears each flag whose bit is written 1. Bits written 0 leave their flag unchanged. A set event in the same cycle as a clear keeps the flag set.
- R7: `cpu_irq` is 1 exactly when some status flag is set and the control enable at the same bit position is 1.
- R8: The discard flag (status bit 15) sets on the 2^15-th clock edge after the edge that latched a delayed read, if no retry was sampled on any of those edges. A retry sampled on the final edge prevents the discard.
- R9: The retry timer does not count while no delayed read is pending, so a retry ends the wait and no discard follows later.
- R10: `ext_rst_out` equals the stored reset bit (bit 0 of the control word).
- R11: Writing bit 0 as 1 while it reads 0 makes `int_rst_strobe` high for exactly the one cycle after the write edge. Writing 1 while it already reads 1, or writing 0, gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write enable |
| csr_addr | input | 1 | Register select: 0 control, 1 status |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data of the selected register (combinational) |
| auto_div | input | 3 | Auto-detected divide code |
| ev_perr | input | 1 | Parity error event |
| ev_serr | input | 1 | System error event |
| ev_xerr | input | 1 | Internal error response event |
| dr_latch | input | 1 | A delayed read has been latched |
| dr_retry | input | 1 | The external master retried the delayed read |
| cpu_irq | output | 1 | Combined CPU interrupt |
| ext_rst_out | output | 1 | External bus reset level |
| int_rst_strobe | output | 1 | One-cycle internal reset strobe |
| div_code | output | 3 | Effective clock-divide code |
| div_reserved | output | 1 | Effective divide code is the reserved value |

## Verification
The divide selector is swept over all 64 pairs of programmed and auto-detected codes. This separates the override path from the fallback path and exposes the reserved code on each side. Each of the three error events is raised under all 16 enable masks. This shows that every flag sets its own bit only and that the interrupt follows its own enable. The retry timer runs three scenarios: a full timeout, a retry on the very last edge, and an early retry followed by a wait longer than the window. Together these distinguish an off-by-one window, a retry/discard priority error and a counter that keeps running while idle.

// File: rtl/brg_csr_pkg.sv
`timescale 1ns/1ps
package brg_csr_pkg;

    localparam int DATA_W  = 32;
    localparam int DIV_W   = 3;
    localparam int NFLAG   = 4;
    localparam int DIV_LSB = 16;
    localparam int RST_BIT = 0;

    // flag indices; enables share the same bit positions
    localparam int FI_XERR = 0;
    localparam int FI_SERR = 1;
    localparam int FI_PERR = 2;
    localparam int FI_DRD  = 3;

    typedef enum logic [DIV_W-1:0] {
        DIV_AUTO = 3'd0,
        DIV_BY1  = 3'd1,
        DIV_BY2  = 3'd2,
        DIV_BY3  = 3'd3,
        DIV_BY4  = 3'd4,
        DIV_BY5  = 3'd5,
        DIV_BY1P5 = 3'd6,
        DIV_RSV  = 3'd7
    } div_code_e;

    typedef enum logic [0:0] {
        SEL_CTRL = 1'b0,
        SEL_STAT = 1'b1
    } csr_sel_e;

    typedef struct packed {
        div_code_e        div;
        logic [NFLAG-1:0] en;
        logic             rst_bit;
    } ctl_t;

    function automatic int flag_bit(input int idx);
        case (idx)
            FI_XERR: return 11;
            FI_SERR: return 12;
            FI_PERR: return 13;
            default: return 15;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_flags(input logic [NFLAG-1:0] f);
        logic [DATA_W-1:0] w;
        w = '0;
        for (int i = 0; i < NFLAG; i++) w[flag_bit(i)] = f[i];
        return w;
    endfunction

    function automatic logic [NFLAG-1:0] unpack_flags(input logic [DATA_W-1:0] d);
        logic [NFLAG-1:0] f;
        for (int i = 0; i < NFLAG; i++) f[i] = d[flag_bit(i)];
        return f;
    endfunction

    function automatic div_code_e pick_div(input div_code_e prg, input logic [DIV_W-1:0] auto_c);
        return (prg != DIV_AUTO) ? prg : div_code_e'(auto_c);
    endfunction

endpackage

// File: rtl/brg_ctrl_reg.sv
`timescale 1ns/1ps
module brg_ctrl_reg
    import brg_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctl,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl_q,
    output logic              strobe_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.div     <= DIV_AUTO;
            ctl_q.en      <= '0;
            ctl_q.rst_bit <= 1'b1;
            strobe_q      <= 1'b0;
        end else begin
            // rising transition of the reset bit by software
            strobe_q <= wr_ctl & wdata[RST_BIT] & ~ctl_q.rst_bit;
            if (wr_ctl) begin
                ctl_q.div     <= div_code_e'(wdata[DIV_LSB +: DIV_W]);
                ctl_q.en      <= unpack_flags(wdata);
                ctl_q.rst_bit <= wdata[RST_BIT];
            end
        end
    end

endmodule

// File: rtl/brg_retry_timer.sv
`timescale 1ns/1ps
module brg_retry_timer #(
    parameter int LIMIT_LOG2 = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic latch_i,
    input  logic retry_i,
    output logic pending_o,
    output logic fire_o
);

    localparam logic [LIMIT_LOG2-1:0] LAST = '1;

    logic [LIMIT_LOG2-1:0] cnt_q;

    assign fire_o = pending_o & ~retry_i & ~latch_i & (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_o <= 1'b0;
            cnt_q     <= '0;
        end else if (latch_i) begin
            pending_o <= 1'b1;
            cnt_q     <= '0;
        end else if (pending_o) begin
            if (retry_i || fire_o) begin
                pending_o <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/brg_sticky_flags.sv
`timescale 1ns/1ps
module brg_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)           flag_o[g] <= 1'b0;
            else if (set_i[g]) flag_o[g] <= 1'b1;
            else if (clr_i[g]) flag_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/brg_csr_unit.sv
`timescale 1ns/1ps
module brg_csr_unit
    import brg_csr_pkg::*;
#(
    parameter int RETRY_LOG2 = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic              csr_addr,
    input  logic [DATA_W-1:0] csr_wdata,
    output logic [DATA_W-1:0] csr_rdata,
    input  logic [DIV_W-1:0]  auto_div,
    input  logic              ev_perr,
    input  logic              ev_serr,
    input  logic              ev_xerr,
    input  logic              dr_latch,
    input  logic              dr_retry,
    output logic              cpu_irq,
    output logic              ext_rst_out,
    output logic              int_rst_strobe,
    output logic [DIV_W-1:0]  div_code,
    output logic              div_reserved
);

    ctl_t             ctl_q;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic             tmr_pending;
    logic             tmr_fire;
    logic             wr_ctl;
    logic             wr_stat;
    div_code_e        eff_div;
    logic [DATA_W-1:0] ctl_word;

    assign wr_ctl  = csr_wr & (csr_sel_e'(csr_addr) == SEL_CTRL);
    assign wr_stat = csr_wr & (csr_sel_e'(csr_addr) == SEL_STAT);

    brg_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_ctl   (wr_ctl),
        .wdata    (csr_wdata),
        .ctl_q    (ctl_q),
        .strobe_q (int_rst_strobe)
    );

    brg_retry_timer #(.LIMIT_LOG2(RETRY_LOG2)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .latch_i   (dr_latch),
        .retry_i   (dr_retry),
        .pending_o (tmr_pending),
        .fire_o    (tmr_fire)
    );

    always_comb begin
        flag_set          = '0;
        flag_set[FI_XERR] = ev_xerr;
        flag_set[FI_SERR] = ev_serr;
        flag_set[FI_PERR] = ev_perr;
        flag_set[FI_DRD]  = tmr_fire;
        flag_clr = wr_stat ? unpack_flags(csr_wdata) : '0;
    end

    brg_sticky_flags #(.N(NFLAG)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flag_q)
    );

    assign cpu_irq     = |(flag_q & ctl_q.en);
    assign ext_rst_out = ctl_q.rst_bit;

    assign eff_div      = pick_div(ctl_q.div, auto_div);
    assign div_code     = eff_div;
    assign div_reserved = (eff_div == DIV_RSV);

    always_comb begin
        ctl_word = pack_flags(ctl_q.en);
        ctl_word[DIV_LSB +: DIV_W] = ctl_q.div;
        ctl_word[RST_BIT] = ctl_q.rst_bit;
        csr_rdata = (csr_sel_e'(csr_addr) == SEL_STAT) ? pack_flags(flag_q) : ctl_word;
    end

endmodule

// File: rtl/brg_csr_chk.sv
`timescale 1ns/1ps
module brg_csr_chk (
    input logic        clk,
    input logic        rst,
    input logic        csr_wr,
    input logic        csr_addr,
    input logic [31:0] csr_wdata,
    input logic        ext_rst_out,
    input logic        int_rst_strobe,
    input logic [2:0]  div_code,
    input logic        ev_perr,
    input logic [3:0]  flags,
    input logic        pending
);

    // R3
    prg_override_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !csr_addr && csr_wdata[18:16] != 3'd0) |=> div_code == $past(csr_wdata[18:16]));

    // R10
    ext_rst_track_chk: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && !csr_addr) |=> ext_rst_out == $past(csr_wdata[0]));

    // R11
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        int_rst_strobe |=> !int_rst_strobe);

    // R11
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_rst_strobe) |-> $past(csr_wr && !csr_addr && csr_wdata[0] && !ext_rst_out));

    // R5
    perr_set_chk: assert property (@(posedge clk) disable iff (rst)
        ev_perr |=> flags[2]);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (flags[2] && !(csr_wr && csr_addr && csr_wdata[13])) |=> flags[2]);

    // R8
    discard_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[3]) |-> $past(pending));

endmodule

bind brg_csr_unit brg_csr_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .csr_wr         (csr_wr),
    .csr_addr       (csr_addr),
    .csr_wdata      (csr_wdata),
    .ext_rst_out    (ext_rst_out),
    .int_rst_strobe (int_rst_strobe),
    .div_code       (div_code),
    .ev_perr        (ev_perr),
    .flags          (flag_q),
    .pending        (tmr_pending)
);

// File: tb/brg_csr_unit_test.sv
`timescale 1ns/1ps
module brg_csr_unit_test;

    localparam int LIMIT = 1 << 15;
    localparam int FB [4] = '{11, 12, 13, 15};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic        csr_addr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [2:0]  auto_div = 3'd0;
    logic        ev_perr = 1'b0, ev_serr = 1'b0, ev_xerr = 1'b0;
    logic        dr_latch = 1'b0, dr_retry = 1'b0;
    logic        cpu_irq, ext_rst_out, int_rst_strobe, div_reserved;
    logic [2:0]  div_code;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    brg_csr_unit uut (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .auto_div(auto_div),
        .ev_perr(ev_perr), .ev_serr(ev_serr), .ev_xerr(ev_xerr),
        .dr_latch(dr_latch), .dr_retry(dr_retry), .cpu_irq(cpu_irq),
        .ext_rst_out(ext_rst_out), .int_rst_strobe(int_rst_strobe),
        .div_code(div_code), .div_reserved(div_reserved)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    function automatic logic [31:0] fmask(input logic [3:0] f);
        logic [31:0] w = '0;
        for (int i = 0; i < 4; i++) if (f[i]) w[FB[i]] = 1'b1;
        return w;
    endfunction

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(1'b0, r); check("R1 ctrl", r, 32'h1);
        rd(1'b1, r); check("R1 status", r, 32'h0);
        check("R1 ext_rst", ext_rst_out, 1);
        check("R1 irq", cpu_irq, 0);
        check("R1 strobe", int_rst_strobe, 0);

        // R2 field storage and reserved bits; R11 no strobe when already 1
        wr(1'b0, 32'hFFFF_FFFF);
        check("R11 no strobe when set", int_rst_strobe, 0);
        rd(1'b0, r); check("R2 readback", r, 32'h0007_B801);
        wr(1'b0, 32'h0);
        rd(1'b0, r); check("R2 clear", r, 32'h0);
        check("R10 ext_rst low", ext_rst_out, 0);
        check("R11 no strobe on 0", int_rst_strobe, 0);

        // R3 R4 divide sweep
        for (int p = 0; p < 8; p++) begin
            wr(1'b0, 32'(p) << 16);
            for (int a = 0; a < 8; a++) begin
                logic [2:0] e;
                auto_div = 3'(a);
                #1;
                e = (p != 0) ? 3'(p) : 3'(a);
                check("R3 div_code", 32'(div_code), 32'(e));
                check("R4 reserved", 32'(div_reserved), 32'(e == 3'd7));
            end
        end
        auto_div = 3'd0;

        // R11 strobe on 0 -> 1
        wr(1'b0, 32'h1);
        check("R11 strobe high", int_rst_strobe, 1);
        check("R10 ext_rst high", ext_rst_out, 1);
        @(negedge clk);
        check("R11 strobe one cycle", int_rst_strobe, 0);
        wr(1'b0, 32'h0);

        // R5 R7 event x enable sweep
        for (int m = 0; m < 16; m++) begin
            for (int f = 0; f < 3; f++) begin
                wr(1'b1, 32'hFFFF_FFFF);
                wr(1'b0, fmask(4'(m)));
                @(negedge clk);
                ev_xerr = (f == 0); ev_serr = (f == 1); ev_perr = (f == 2);
                @(negedge clk);
                ev_xerr = 0; ev_serr = 0; ev_perr = 0;
                @(negedge clk);
                rd(1'b1, r);
                check("R5 flag set sticky", r, fmask(4'(1 << f)));
                check("R7 irq", cpu_irq, m[f]);
            end
        end

        // R6 write-one-to-clear and set priority
        wr(1'b1, 32'hFFFF_FFFF);
        wr(1'b0, fmask(4'hF));
        @(negedge clk); ev_perr = 1; @(negedge clk); ev_perr = 0;
        wr(1'b1, 32'h0);
        rd(1'b1, r); check("R6 write zero keeps", r, fmask(4'b0100));
        wr(1'b1, fmask(4'b1011));
        rd(1'b1, r); check("R6 other bits keep", r, fmask(4'b0100));
        wr(1'b1, fmask(4'b0100));
        rd(1'b1, r); check("R6 clear", r, 32'h0);
        check("R7 irq drops", cpu_irq, 0);
        @(negedge clk);
        ev_serr = 1; csr_wr = 1; csr_addr = 1; csr_wdata = fmask(4'b0010);
        @(negedge clk);
        ev_serr = 0; csr_wr = 0; csr_wdata = '0;
        rd(1'b1, r); check("R6 set wins", r, fmask(4'b0010));
        wr(1'b1, 32'hFFFF_FFFF);

        // R8 full timeout
        @(negedge clk); dr_latch = 1; @(negedge clk); dr_latch = 0;
        repeat (LIMIT - 1) @(negedge clk);
        rd(1'b1, r); check("R8 before window end", r, 32'h0);
        @(negedge clk);
        rd(1'b1, r); check("R8 discard", r, fmask(4'b1000));
        check("R7 discard irq", cpu_irq, 1);
        wr(1'b1, 32'hFFFF_FFFF);

        // R8 retry on final edge
        @(negedge clk); dr_latch = 1; @(negedge clk); dr_latch = 0;
        repeat (LIMIT - 1) @(negedge clk);
        dr_retry = 1; @(negedge clk); dr_retry = 0;
        repeat (4) @(negedge clk);
        rd(1'b1, r); check("R8 last-edge retry", r, 32'h0);

        // R9 idle does not count
        @(negedge clk); dr_latch = 1; @(negedge clk); dr_latch = 0;
        repeat (100) @(negedge clk);
        dr_retry = 1; @(negedge clk); dr_retry = 0;
        repeat (LIMIT + 10) @(negedge clk);
        rd(1'b1, r); check("R9 no discard when idle", r, 32'h0);
        check("R9 irq", cpu_irq, 0);

        done = 1'b1;
        summary();
    end

endmodule